// File: doc/BRIEF.md
# CPU Idle Phase Sequencer

This controller steps one processor core through its low-power life cycle. A core that is running sits in the execute phase. When software asks for an idle state, the controller moves it through an optional, abortable preparation phase and then a committed entry phase. After that comes the idle phase proper, and finally an exit phase that brings the core back to execution. The request carries the chosen state's entry and exit latencies, counted in one-microsecond ticks. It also carries two flags: one says whether the state has a preparation phase, and one says whether the state loses the local timer context.

Preparation stands in for work such as cache cleaning, and it ends on a done strobe from that logic. A wake-up event during preparation cancels the sequence. Once the entry phase has begun it always finishes. A wake-up that arrives during entry is held and is served as soon as entry ends. Throughout the sequence the block publishes a live estimate of the worst-case delay to get the core running again. That estimate falls as entry time passes. The block also drives a flag for lost timer context, a flag showing that entry is in progress, and a one-cycle pulse when the core is back in execution.

Top module: `idle_phase_seq`

## Requirements
- R1: `phase_o` encodes the phases as execute=0, prepare=1, entry=2, idle=3, exit=4. The only paths are 0→1, 0→2, 1→0, 1→2, 2→3, 2→4, 3→4 and 4→0.
- R2: In the prepare phase, a `wake` sampled at a clock edge returns the block to execute at that edge, even when `prep_done` is high at the same edge.
- R3: A request accepted with `req_abortable`=0 goes from execute straight to entry at the accepting edge. With `req_abortable`=1 it goes to prepare, and `prep_done` then moves it to entry.
- R4: Entry ignores `wake` and stays active until `req_entry_lat` ticks have been counted. It leaves at the first edge after the count reaches zero, so with the tick held high it lasts entry latency + 1 cycles. A latency of zero gives one cycle, and with the tick low the count holds.
- R5: Idle lasts until `wake` is sampled and then moves to exit at that edge.
- R6: A `wake` seen at any edge during entry makes the block go from entry straight to exit, with zero cycles in idle.
- R7: Exit counts `req_exit_lat` ticks, so with the tick held high it lasts exit latency + 1 cycles. Execute follows.
- R8: `wake_delay_o` is 0 in execute and exit latency + entry latency in prepare. In entry and idle it is exit latency + max(entry latency − ticks elapsed since entry began, 0). In exit it is the exit ticks still left.
- R9: `timer_lost_o` rises together with the entry phase when `req_timer_stop` was 1 in the request. It stays high until exit returns to execute, and it is never set by a state that keeps the timer or by an aborted sequence.
- R10: Requests seen outside the execute phase are dropped. They change neither the phase nor the latched latencies, which shows in `wake_delay_o`.
- R11: `done_o` is high for exactly the first cycle back in execute after any sequence, including an aborted one.
- R12: A synchronous active-high `rst` puts the block in execute with every counter cleared and all outputs at 0.
- R13: `entry_busy_o` is high exactly while the phase is entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-microsecond tick enable |
| req_valid | input | 1 | Idle request strobe |
| req_entry_lat | input | LAT_W | Entry latency of the chosen state, in ticks |
| req_exit_lat | input | LAT_W | Exit latency of the chosen state, in ticks |
| req_abortable | input | 1 | 1: state has an abortable prepare phase |
| req_timer_stop | input | 1 | 1: state loses local timer context |
| prep_done | input | 1 | Preparation finished strobe |
| wake | input | 1 | Wake-up event |
| phase_o | output | 3 | Current phase code |
| entry_busy_o | output | 1 | Entry phase in progress |
| timer_lost_o | output | 1 | Local timer context lost |
| wake_delay_o | output | LAT_W+1 | Worst-case wake-up delay estimate, in ticks |
| done_o | output | 1 | One-cycle pulse on return to execute |

## Verification
A corrupted latency counter appears within one tick: `wake_delay_o` leaves its expected downward ramp during entry, and the number of cycles spent in entry or exit no longer matches latency + 1. A wrong phase transition appears on `phase_o` in the very next cycle, where the scoreboard's list of expected phases catches it. A lost pending wake-up shows up as an idle phase that never ends. A wrong timer flag or done pulse shows up at the first execute cycle after exit.

// File: rtl/idle_seq_pkg.sv
package idle_seq_pkg;
  typedef enum logic [2:0] {
    PH_EXEC  = 3'd0,
    PH_PREP  = 3'd1,
    PH_ENTRY = 3'd2,
    PH_IDLE  = 3'd3,
    PH_EXIT  = 3'd4
  } phase_e;
endpackage

// File: rtl/idle_lat_counter.sv
module idle_lat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec_en,
  output logic [W-1:0] cnt,
  output logic         zero
);
  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (dec_en && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // a spent count must not wrap around
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    zero && !load |=> zero); // R7
endmodule

// File: rtl/idle_elapsed_counter.sv
module idle_elapsed_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc_en,
  output logic [W-1:0] elapsed
);
  localparam logic [W-1:0] SAT = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)                     elapsed <= '0;
    else if (inc_en && elapsed != SAT)  elapsed <= elapsed + 1'b1;
  end

  AST_ELAPSED_MONOTONIC: assert property (@(posedge clk) disable iff (rst)
    !clr |=> elapsed >= $past(elapsed)); // R8
endmodule

// File: rtl/idle_delay_est.sv
module idle_delay_est
  import idle_seq_pkg::*;
#(
  parameter int W = 16
) (
  input  phase_e       phase,
  input  logic [W-1:0] entry_lat,
  input  logic [W-1:0] exit_lat,
  input  logic [W-1:0] elapsed,
  input  logic [W-1:0] exit_left,
  output logic [W:0]   delay
);
  function automatic logic [W-1:0] entry_left(input logic [W-1:0] lat,
                                              input logic [W-1:0] spent);
    return (lat > spent) ? lat - spent : '0;
  endfunction

  function automatic logic [W:0] add_wide(input logic [W-1:0] a,
                                          input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  always_comb begin
    case (phase)
      PH_PREP:           delay = add_wide(exit_lat, entry_lat);
      PH_ENTRY, PH_IDLE: delay = add_wide(exit_lat, entry_left(entry_lat, elapsed));
      PH_EXIT:           delay = {1'b0, exit_left};
      default:           delay = '0;
    endcase
  end
endmodule

// File: rtl/idle_phase_seq.sv
module idle_phase_seq
  import idle_seq_pkg::*;
#(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_us,
  input  logic             req_valid,
  input  logic [LAT_W-1:0] req_entry_lat,
  input  logic [LAT_W-1:0] req_exit_lat,
  input  logic             req_abortable,
  input  logic             req_timer_stop,
  input  logic             prep_done,
  input  logic             wake,
  output logic [2:0]       phase_o,
  output logic             entry_busy_o,
  output logic             timer_lost_o,
  output logic [LAT_W:0]   wake_delay_o,
  output logic             done_o
);
  phase_e             phase_q, phase_d;
  logic [LAT_W-1:0]   entry_lat_q, exit_lat_q;
  logic               stop_q, wake_pend_q, timer_lost_q, done_q;
  logic               cnt_load, cnt_zero, cnt_dec;
  logic [LAT_W-1:0]   cnt_val, cnt;
  logic [LAT_W-1:0]   elapsed;

  // named internal events
  logic accept_req, entry_start, back_to_exec, stop_sel, elapse_en;

  assign accept_req   = (phase_q == PH_EXEC) && req_valid;
  assign entry_start  = (phase_d == PH_ENTRY) && (phase_q != PH_ENTRY);
  assign back_to_exec = (phase_d == PH_EXEC) && (phase_q != PH_EXEC);
  assign stop_sel     = (phase_q == PH_EXEC) ? req_timer_stop : stop_q;
  assign cnt_dec      = tick_us && (phase_q == PH_ENTRY || phase_q == PH_EXIT);
  assign elapse_en    = tick_us && (phase_q == PH_ENTRY || phase_q == PH_IDLE);

  always_comb begin
    phase_d  = phase_q;
    cnt_load = 1'b0;
    cnt_val  = entry_lat_q;
    case (phase_q)
      PH_EXEC: if (req_valid) begin
        if (req_abortable) phase_d = PH_PREP;
        else begin
          phase_d  = PH_ENTRY;
          cnt_load = 1'b1;
          cnt_val  = req_entry_lat;
        end
      end
      PH_PREP: begin
        if (wake) phase_d = PH_EXEC;
        else if (prep_done) begin
          phase_d  = PH_ENTRY;
          cnt_load = 1'b1;
          cnt_val  = entry_lat_q;
        end
      end
      PH_ENTRY: if (cnt_zero) begin
        if (wake_pend_q || wake) begin
          phase_d  = PH_EXIT;
          cnt_load = 1'b1;
          cnt_val  = exit_lat_q;
        end else phase_d = PH_IDLE;
      end
      PH_IDLE: if (wake) begin
        phase_d  = PH_EXIT;
        cnt_load = 1'b1;
        cnt_val  = exit_lat_q;
      end
      PH_EXIT: if (cnt_zero) phase_d = PH_EXEC;
      default: phase_d = PH_EXEC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q      <= PH_EXEC;
      entry_lat_q  <= '0;
      exit_lat_q   <= '0;
      stop_q       <= 1'b0;
      wake_pend_q  <= 1'b0;
      timer_lost_q <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= back_to_exec;
      if (accept_req) begin
        entry_lat_q <= req_entry_lat;
        exit_lat_q  <= req_exit_lat;
        stop_q      <= req_timer_stop;
      end
      if (entry_start)                         wake_pend_q <= 1'b0;
      else if (phase_q == PH_ENTRY && wake)    wake_pend_q <= 1'b1;
      if (entry_start && stop_sel)             timer_lost_q <= 1'b1;
      else if (back_to_exec)                   timer_lost_q <= 1'b0;
    end
  end

  idle_lat_counter #(.W(LAT_W)) u_lat_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val),
    .dec_en(cnt_dec), .cnt(cnt), .zero(cnt_zero)
  );

  idle_elapsed_counter #(.W(LAT_W)) u_elapsed (
    .clk(clk), .rst(rst), .clr(entry_start), .inc_en(elapse_en),
    .elapsed(elapsed)
  );

  idle_delay_est #(.W(LAT_W)) u_delay (
    .phase(phase_q), .entry_lat(entry_lat_q), .exit_lat(exit_lat_q),
    .elapsed(elapsed), .exit_left(cnt), .delay(wake_delay_o)
  );

  assign phase_o      = phase_q;
  assign entry_busy_o = (phase_q == PH_ENTRY);
  assign timer_lost_o = timer_lost_q;
  assign done_o       = done_q;

  AST_IDLE_NEXT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_IDLE |=> (phase_q == PH_IDLE || phase_q == PH_EXIT)); // R1
  AST_PREP_ABORT: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_PREP && wake |=> phase_q == PH_EXEC); // R2
  AST_ENTRY_COMMITTED: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_ENTRY && !cnt_zero |=> phase_q == PH_ENTRY); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_IDLE && !wake |=> phase_q == PH_IDLE); // R5
  AST_PENDING_WAKE: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_ENTRY && cnt_zero && wake_pend_q |=> phase_q == PH_EXIT); // R6
  AST_TIMER_HELD: assert property (@(posedge clk) disable iff (rst)
    timer_lost_q && phase_q != PH_EXIT |=> timer_lost_q); // R9
  AST_REQ_DROPPED: assert property (@(posedge clk) disable iff (rst)
    phase_q != PH_EXEC && req_valid |=> $stable(exit_lat_q) && $stable(entry_lat_q)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R11
endmodule

// File: tb/idle_phase_seq_bench.sv
module idle_phase_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst, tick_us, req_valid, req_abortable, req_timer_stop;
  logic          prep_done, wake;
  logic [LW-1:0] req_entry_lat, req_exit_lat;
  logic [2:0]    phase_o;
  logic          entry_busy_o, timer_lost_o, done_o;
  logic [LW:0]   wake_delay_o;

  int tests = 0;
  int fails = 0;
  int n;
  int exp_ph;
  bit finished = 0;
  int exp_q[$];
  logic [2:0] prev_ph = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_phase_seq #(.LAT_W(LW)) u_idle_phase_seq (
    .clk(clk), .rst(rst), .tick_us(tick_us), .req_valid(req_valid),
    .req_entry_lat(req_entry_lat), .req_exit_lat(req_exit_lat),
    .req_abortable(req_abortable), .req_timer_stop(req_timer_stop),
    .prep_done(prep_done), .wake(wake), .phase_o(phase_o),
    .entry_busy_o(entry_busy_o), .timer_lost_o(timer_lost_o),
    .wake_delay_o(wake_delay_o), .done_o(done_o)
  );

  task automatic check(input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic nx();
    @(negedge clk);
  endtask

  // driver: issues a request and queues the phases it should produce
  task automatic issue(input bit abrt, input int lat_in, input int lat_out,
                       input bit stop, input int phases[$]);
    foreach (phases[i]) exp_q.push_back(phases[i]);
    req_valid      = 1'b1;
    req_abortable  = abrt;
    req_entry_lat  = LW'(lat_in);
    req_exit_lat   = LW'(lat_out);
    req_timer_stop = stop;
    nx();
    req_valid = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // monitor: every phase change must match the next queued phase (R1)
  always @(negedge clk) begin
    if (!rst && phase_o != prev_ph) begin
      if (exp_q.size() == 0) check("R1 unexpected phase", int'(phase_o), -1);
      else begin
        exp_ph = exp_q.pop_front();
        check("R1 phase order", int'(phase_o), exp_ph);
      end
      prev_ph = phase_o;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 1, 0);
    report();
  end

  initial begin
    rst = 1'b1; tick_us = 1'b1; req_valid = 1'b0; req_abortable = 1'b0;
    req_timer_stop = 1'b0; prep_done = 1'b0; wake = 1'b0;
    req_entry_lat = '0; req_exit_lat = '0;
    repeat (3) nx();
    check("R12 phase", int'(phase_o), 0);
    check("R12 timer_lost", int'(timer_lost_o), 0);
    check("R12 wake_delay", int'(wake_delay_o), 0);
    check("R12 done", int'(done_o), 0);
    check("R12 entry_busy", int'(entry_busy_o), 0);
    rst = 1'b0;
    nx();

    // full abortable sequence: entry 3, exit 5, timer lost
    issue(1'b1, 3, 5, 1'b1, '{1, 2, 3, 4, 0});
    check("R3 prepare", int'(phase_o), 1);
    check("R8 prep delay", int'(wake_delay_o), 8);
    check("R9 not yet lost", int'(timer_lost_o), 0);
    req_valid = 1'b1; req_entry_lat = 9; req_exit_lat = 9; req_abortable = 1'b0;
    nx(); req_valid = 1'b0;
    check("R10 phase kept", int'(phase_o), 1);
    check("R10 latencies kept", int'(wake_delay_o), 8);
    prep_done = 1'b1; nx(); prep_done = 1'b0;
    check("R13 entry busy", int'(entry_busy_o), 1);
    check("R9 lost at entry", int'(timer_lost_o), 1);
    check("R8 entry start delay", int'(wake_delay_o), 8);
    nx();
    check("R8 delay shrinks", int'(wake_delay_o), 7);
    n = 2; nx();
    while (phase_o == 3'd2) begin n++; nx(); end
    check("R4 entry length", n, 4);
    check("R8 idle delay", int'(wake_delay_o), 5);
    check("R13 busy low in idle", int'(entry_busy_o), 0);
    repeat (5) nx();
    check("R5 idle holds", int'(phase_o), 3);
    check("R9 lost in idle", int'(timer_lost_o), 1);
    wake = 1'b1; nx(); wake = 1'b0;
    check("R5 wake to exit", int'(phase_o), 4);
    check("R8 exit delay", int'(wake_delay_o), 5);
    n = 1; nx();
    while (phase_o == 3'd4) begin n++; nx(); end
    check("R7 exit length", n, 6);
    check("R11 done pulse", int'(done_o), 1);
    check("R9 lost cleared", int'(timer_lost_o), 0);
    nx();
    check("R11 done one cycle", int'(done_o), 0);

    // abort in prepare, wake wins over prep_done
    issue(1'b1, 4, 4, 1'b1, '{1, 0});
    wake = 1'b1; prep_done = 1'b1; nx(); wake = 1'b0; prep_done = 1'b0;
    check("R2 abort to exec", int'(phase_o), 0);
    check("R11 done on abort", int'(done_o), 1);
    check("R9 no loss on abort", int'(timer_lost_o), 0);
    check("R8 exec delay", int'(wake_delay_o), 0);
    nx();

    // non-abortable with wake during entry: idle skipped
    issue(1'b0, 2, 1, 1'b0, '{2, 4, 0});
    check("R3 straight to entry", int'(phase_o), 2);
    check("R9 timer kept", int'(timer_lost_o), 0);
    wake = 1'b1; nx(); wake = 1'b0;
    check("R4 wake ignored in entry", int'(phase_o), 2);
    while (phase_o == 3'd2) nx();
    check("R6 entry to exit", int'(phase_o), 4);
    n = 1; nx();
    while (phase_o == 3'd4) begin n++; nx(); end
    check("R7 short exit", n, 2);
    nx();

    // tick stall holds entry
    issue(1'b0, 2, 0, 1'b0, '{2, 3, 4, 0});
    tick_us = 1'b0;
    repeat (4) nx();
    check("R4 stalled entry", int'(phase_o), 2);
    check("R8 stalled delay", int'(wake_delay_o), 2);
    tick_us = 1'b1;
    while (phase_o == 3'd2) nx();
    check("R5 reached idle", int'(phase_o), 3);
    wake = 1'b1; nx(); wake = 1'b0;
    check("R7 zero exit", int'(phase_o), 4);
    nx();
    check("R7 back to exec", int'(phase_o), 0);
    nx();

    // zero entry latency, request ignored while idle
    issue(1'b0, 0, 0, 1'b0, '{2, 3, 4, 0});
    check("R4 zero entry cycle", int'(phase_o), 2);
    nx();
    check("R4 zero entry done", int'(phase_o), 3);
    req_valid = 1'b1; req_entry_lat = 7; req_exit_lat = 7;
    nx(); req_valid = 1'b0;
    check("R10 idle ignores req", int'(phase_o), 3);
    check("R10 idle delay kept", int'(wake_delay_o), 0);
    wake = 1'b1; nx(); wake = 1'b0;
    nx();
    check("R7 exec after exit", int'(phase_o), 0);
    repeat (2) nx();
    check("R1 all phases seen", exp_q.size(), 0);
    report();
  end
endmodule